// File: doc/BRIEF.md
# Token-List I2C Master

This block is an I2C master that does not take bus commands one byte at a time. Software loads a list of up to sixteen 4-bit opcodes, up to eight bytes of transmit data and a target address, then raises a start bit. The engine walks the list from the lowest nibble upward. Each opcode becomes one bus phase: a START, an address byte, a data byte, a final read byte or a STOP. Bytes that are read back are packed into a 64-bit read buffer. A busy flag tracks the run, and an error flag records a target that refused a byte.

SCL and SDA are open-drain. Each line has an output that, when high, pulls the wire low. SDA is also sampled back through an input. Every bit lasts four quarter periods. A programmable divider sets the length of a quarter, in system clocks.

Top module: `tokseq_i2c_master`

## Requirements
- R1: After reset, every register reads 0, busy and error are 0, and neither line is pulled low.
- R2: The register port uses word indices. 0 is control, 1 is target address, 2 and 3 are the token list low and high words, 4 and 5 are write data low and high, and 6 and 7 are read data low and high. A read returns the selected register one clock after the index is presented.
- R3: A 0-to-1 change of control bit 0 starts a run, and control bit 2 reads 1 while the run lasts. Tokens execute in order from bits [3:0] upward. A run ends at the first token of value 0, or after the sixteenth token.
- R4: Token 1 makes a START. Tokens 2 and 3 send address-register bits [7:1] followed by a direction bit: 0 for token 2, 1 for token 3.
- R5: In a write phase, token 4 sends the next write-data byte. Byte k is taken from bits [8k+7:8k] of the 64-bit write data, starting at k=0 for each run.
- R6: After token 3, token 4 reads a byte and answers ACK. Token 5 reads a byte and answers NACK. Read byte k is stored at bits [8k+7:8k] of the 64-bit read data, which is cleared at the start of each run.
- R7: A NACK on an address byte or a write byte sets control bit 3, skips the rest of the list and issues a STOP. When busy drops, both lines are released. Bit 3 is cleared when the next run starts.
- R8: A START token issued while the bus is held produces a repeated START. Token 6 makes a STOP.
- R9: The quarter-period length q, in clocks, is {control[31:28], control[21:12]}. SCL stays high for 2q clocks in each data bit.
- R10: Within a byte, SDA changes only while SCL is pulled low.
- R11: A run that ends without a STOP leaves SCL pulled low, so the bus is kept for the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_word | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | Sampled SDA level |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
A token pointer in the wrong state shows up on the bus within one byte time, as a phase in the wrong place. The bus model records the START and STOP counts, the address and data bytes, and the acknowledge pattern, so a skipped, repeated or misdecoded opcode changes those records before busy drops. A byte index in the wrong state shows up as a misplaced byte in the target's log or in the read-data words, which are read back as soon as the run ends. A fault in the divider or the phase counter changes the measured SCL high time in the first data bit.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam logic [3:0] TK_END    = 4'd0;
  localparam logic [3:0] TK_START  = 4'd1;
  localparam logic [3:0] TK_ADDR_W = 4'd2;
  localparam logic [3:0] TK_ADDR_R = 4'd3;
  localparam logic [3:0] TK_DATA   = 4'd4;
  localparam logic [3:0] TK_LAST   = 4'd5;
  localparam logic [3:0] TK_STOP   = 4'd6;

  typedef enum logic [1:0] {PC_START, PC_STOP, PC_BYTE} pcmd_e;
  typedef enum logic [2:0] {SQ_IDLE, SQ_FETCH, SQ_WAIT, SQ_ABORT, SQ_ABWAIT} sq_e;
endpackage

// File: rtl/tsq_clkdiv.sv
module tsq_clkdiv #(
  parameter int QW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [QW-1:0] quarter,
  output logic          tick
);
  logic [QW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (({1'b0, cnt} + 1'b1) >= {1'b0, quarter}) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/tsq_bitphy.sv
module tsq_bitphy
  import tsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       cmd_valid,
  input  pcmd_e      cmd_kind,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_rx,
  input  logic       cmd_ack,
  input  logic       sda_in,
  output logic       running,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       nack,
  output logic       scl_oe,
  output logic       sda_oe
);
  pcmd_e      kind;
  logic [1:0] phase;
  logic [3:0] bitn;
  logic [7:0] txsh;
  logic       rxmode, ackbit, held;
  logic       scl_d, sda_d;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      running <= 1'b0;
      kind    <= PC_START;
      phase   <= 2'd0;
      bitn    <= 4'd0;
      txsh    <= 8'd0;
      rx_byte <= 8'd0;
      nack    <= 1'b0;
      rxmode  <= 1'b0;
      ackbit  <= 1'b0;
      held    <= 1'b0;
    end else if (!running) begin
      if (cmd_valid) begin
        running <= 1'b1;
        kind    <= cmd_kind;
        phase   <= (cmd_kind == PC_START && !held) ? 2'd1 : 2'd0;
        bitn    <= 4'd0;
        txsh    <= cmd_byte;
        rxmode  <= cmd_rx;
        ackbit  <= cmd_ack;
      end
    end else if (tick) begin
      if (kind == PC_BYTE && phase == 2'd1) begin
        if (bitn < 4'd8) rx_byte <= {rx_byte[6:0], sda_in};
        else             nack    <= sda_in;
      end
      if (phase == 2'd3) begin
        if (kind == PC_BYTE && bitn < 4'd8) begin
          bitn  <= bitn + 1'b1;
          txsh  <= {txsh[6:0], 1'b0};
          phase <= 2'd0;
        end else begin
          running <= 1'b0;
          done    <= 1'b1;
          held    <= (kind != PC_STOP);
        end
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_comb begin
    scl_d = held;
    sda_d = 1'b0;
    if (running) begin
      case (kind)
        PC_START: begin
          scl_d = (phase == 2'd0) || (phase == 2'd3);
          sda_d = (phase == 2'd2) || (phase == 2'd3);
        end
        PC_STOP: begin
          scl_d = (phase == 2'd0);
          sda_d = (phase == 2'd0) || (phase == 2'd1);
        end
        default: begin
          scl_d = (phase == 2'd0) || (phase == 2'd3);
          sda_d = (bitn < 4'd8) ? (!rxmode && !txsh[7]) : (rxmode && ackbit);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      scl_oe <= scl_d;
      sda_oe <= sda_d;
    end
  end

  AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (running && kind == PC_BYTE && $past(running && kind == PC_BYTE) && !scl_oe && $past(!scl_oe))
      |-> $stable(sda_oe)); // R10
endmodule

// File: rtl/tsq_seq.sv
module tsq_seq
  import tsq_pkg::*;
#(
  parameter int NTOK  = 16,
  parameter int NBYTE = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [NTOK*4-1:0]  tokens,
  input  logic [NBYTE*8-1:0] wdata,
  input  logic [6:0]         taddr,
  input  logic               phy_done,
  input  logic               phy_nack,
  input  logic [7:0]         phy_rx,
  output logic               busy,
  output logic               err,
  output logic [NBYTE*8-1:0] rdata,
  output logic               cmd_valid,
  output pcmd_e              cmd_kind,
  output logic [7:0]         cmd_byte,
  output logic               cmd_rx,
  output logic               cmd_ack
);
  localparam int TIW = $clog2(NTOK);
  localparam int BIW = $clog2(NBYTE);

  sq_e            st;
  logic [TIW:0]   ti;
  logic [BIW-1:0] widx;
  logic [BIW:0]   ridx;
  logic           rdphase, chk, rdcap;
  logic [3:0]     tok;

  assign tok  = tokens[{ti[TIW-1:0], 2'b00} +: 4];
  assign busy = (st != SQ_IDLE);

  always_ff @(posedge clk) begin
    cmd_valid <= 1'b0;
    if (rst) begin
      st <= SQ_IDLE; ti <= '0; widx <= '0; ridx <= '0;
      rdphase <= 1'b0; chk <= 1'b0; rdcap <= 1'b0; err <= 1'b0;
      rdata <= '0; cmd_kind <= PC_START; cmd_byte <= 8'd0;
      cmd_rx <= 1'b0; cmd_ack <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: if (go) begin
          st <= SQ_FETCH; ti <= '0; widx <= '0; ridx <= '0;
          rdphase <= 1'b0; err <= 1'b0; rdata <= '0;
        end
        SQ_FETCH: begin
          if (ti[TIW] || tok == TK_END) begin
            st <= SQ_IDLE;
          end else begin
            st <= SQ_WAIT; cmd_valid <= 1'b1; chk <= 1'b0; rdcap <= 1'b0;
            cmd_rx <= 1'b0; cmd_ack <= 1'b0; cmd_kind <= PC_BYTE;
            case (tok)
              TK_START: cmd_kind <= PC_START;
              TK_STOP:  cmd_kind <= PC_STOP;
              TK_ADDR_W: begin
                cmd_byte <= {taddr, 1'b0}; chk <= 1'b1; rdphase <= 1'b0;
              end
              TK_ADDR_R: begin
                cmd_byte <= {taddr, 1'b1}; chk <= 1'b1; rdphase <= 1'b1;
              end
              TK_DATA: begin
                if (rdphase) begin
                  cmd_rx <= 1'b1; cmd_ack <= 1'b1; rdcap <= 1'b1;
                end else begin
                  cmd_byte <= wdata[{widx, 3'b000} +: 8]; chk <= 1'b1;
                  widx <= widx + 1'b1;
                end
              end
              TK_LAST: begin
                cmd_rx <= 1'b1; rdcap <= 1'b1;
              end
              default: begin
                st <= SQ_FETCH; cmd_valid <= 1'b0; ti <= ti + 1'b1;
              end
            endcase
          end
        end
        SQ_WAIT: if (phy_done) begin
          if (chk && phy_nack) begin
            err <= 1'b1; st <= SQ_ABORT;
          end else begin
            if (rdcap && !ridx[BIW]) begin
              rdata[{ridx[BIW-1:0], 3'b000} +: 8] <= phy_rx;
              ridx <= ridx + 1'b1;
            end
            ti <= ti + 1'b1; st <= SQ_FETCH;
          end
        end
        SQ_ABORT: begin
          cmd_valid <= 1'b1; cmd_kind <= PC_STOP; chk <= 1'b0; rdcap <= 1'b0;
          st <= SQ_ABWAIT;
        end
        default: if (phy_done) st <= SQ_IDLE;
      endcase
    end
  end

  AST_CMD_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> busy); // R3
  AST_READ_BOUND: assert property (@(posedge clk) disable iff (rst)
    ridx <= NBYTE); // R6
endmodule

// File: rtl/tokseq_i2c_master.sv
module tokseq_i2c_master
  import tsq_pkg::*;
#(
  parameter int QEXT_W = 4,
  parameter int NTOK   = 16,
  parameter int NBYTE  = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [2:0]  reg_word,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        scl_oe,
  input  logic        sda_i,
  output logic        sda_oe
);
  localparam int QLO_W = 10;
  localparam int QW    = QEXT_W + QLO_W;

  logic              ctrl_start, start_d;
  logic [QLO_W-1:0]  qlow;
  logic [QEXT_W-1:0] qext;
  logic [7:0]        addr_r;
  logic [31:0]       tok_lo, tok_hi, wd_lo, wd_hi;
  logic              go, busy, err, tick;
  logic [63:0]       rdata;
  logic              cmd_valid, cmd_rx, cmd_ack;
  pcmd_e             cmd_kind;
  logic [7:0]        cmd_byte, phy_rx;
  logic              phy_running, phy_done, phy_nack;
  logic [31:0]       ctrl_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_start <= 1'b0; start_d <= 1'b0; qlow <= '0; qext <= '0;
      addr_r <= 8'd0; tok_lo <= '0; tok_hi <= '0; wd_lo <= '0; wd_hi <= '0;
    end else begin
      start_d <= ctrl_start;
      if (reg_we) begin
        case (reg_word)
          3'd0: begin
            ctrl_start <= reg_wdata[0];
            qlow       <= reg_wdata[12 +: QLO_W];
            qext       <= reg_wdata[28 +: QEXT_W];
          end
          3'd1: addr_r <= reg_wdata[7:0];
          3'd2: tok_lo <= reg_wdata;
          3'd3: tok_hi <= reg_wdata;
          3'd4: wd_lo  <= reg_wdata;
          3'd5: wd_hi  <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  assign go = ctrl_start && !start_d;

  always_comb begin
    ctrl_view = 32'd0;
    ctrl_view[0] = ctrl_start;
    ctrl_view[2] = busy;
    ctrl_view[3] = err;
    ctrl_view[12 +: QLO_W]  = qlow;
    ctrl_view[28 +: QEXT_W] = qext;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= 32'd0;
    else begin
      case (reg_word)
        3'd0: reg_rdata <= ctrl_view;
        3'd1: reg_rdata <= {24'd0, addr_r};
        3'd2: reg_rdata <= tok_lo;
        3'd3: reg_rdata <= tok_hi;
        3'd4: reg_rdata <= wd_lo;
        3'd5: reg_rdata <= wd_hi;
        3'd6: reg_rdata <= rdata[31:0];
        default: reg_rdata <= rdata[63:32];
      endcase
    end
  end

  tsq_clkdiv #(.QW(QW)) u_div (
    .clk(clk), .rst(rst), .en(phy_running), .quarter({qext, qlow}), .tick(tick)
  );

  tsq_seq #(.NTOK(NTOK), .NBYTE(NBYTE)) u_seq (
    .clk(clk), .rst(rst), .go(go),
    .tokens({tok_hi, tok_lo}), .wdata({wd_hi, wd_lo}), .taddr(addr_r[7:1]),
    .phy_done(phy_done), .phy_nack(phy_nack), .phy_rx(phy_rx),
    .busy(busy), .err(err), .rdata(rdata),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_byte(cmd_byte),
    .cmd_rx(cmd_rx), .cmd_ack(cmd_ack)
  );

  tsq_bitphy u_phy (
    .clk(clk), .rst(rst), .tick(tick),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_byte(cmd_byte),
    .cmd_rx(cmd_rx), .cmd_ack(cmd_ack), .sda_in(sda_i),
    .running(phy_running), .done(phy_done), .rx_byte(phy_rx), .nack(phy_nack),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  AST_CMD_PHY_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !phy_running); // R3
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && err) |-> (!scl_oe && !sda_oe)); // R7
endmodule

// File: tb/tokseq_i2c_master_test.sv
`timescale 1ns/1ps
module tokseq_i2c_master_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_word = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic scl_oe, sda_oe;
  logic tg_sda_low = 1'b0;
  wire scl = ~scl_oe;
  wire sda = ~sda_oe & ~tg_sda_low;

  always #2.5 clk = ~clk;

  tokseq_i2c_master uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_word(reg_word),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_oe(scl_oe), .sda_i(sda), .sda_oe(sda_oe)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // bus target model, address 0x50
  localparam logic [6:0] TGT = 7'h50;
  int start_n, stop_n, rx_n, tx_n, mack_n, hw_n, nack_at, hi_run;
  logic [7:0] rx_log [16];
  logic       mack_log [16];
  int         hw_log [64];
  logic [7:0] addr_log, sh, txsh;
  logic active, first, txm, matched, rdir, skipf, mlast, nflag;
  logic ps = 1'b1, pd = 1'b1;
  int bitc;

  always @(posedge clk) begin
    logic s, d, ack;
    s = scl; d = sda;
    if (s) hi_run++;
    if (ps && !s) begin
      if (hw_n < 64) hw_log[hw_n] = hi_run;
      hw_n++; hi_run = 0;
    end
    if (ps && s && pd && !d) begin
      start_n++; active = 1; first = 1; txm = 0; bitc = 0; skipf = 1; nflag = 0;
      tg_sda_low <= 1'b0;
    end else if (ps && s && !pd && d) begin
      stop_n++; active = 0; tg_sda_low <= 1'b0;
    end else if (active && !ps && s) begin
      if (bitc < 8) begin
        if (!txm) sh = {sh[6:0], d};
      end else if (txm) begin
        mack_log[mack_n] = !d; mack_n++; mlast = !d;
      end
    end else if (active && ps && !s) begin
      if (skipf) skipf = 0;
      else if (bitc < 7) begin
        bitc++;
        if (txm) begin txsh = {txsh[6:0], 1'b0}; tg_sda_low <= !txsh[7]; end
      end else if (bitc == 7) begin
        bitc = 8;
        if (txm) tg_sda_low <= 1'b0;
        else begin
          if (first) begin
            matched = (sh[7:1] == TGT); rdir = sh[0]; addr_log = sh; ack = matched;
          end else begin
            ack = (rx_n != nack_at); rx_log[rx_n] = sh; rx_n++;
            if (!ack) nflag = 1;
          end
          tg_sda_low <= ack;
        end
      end else begin
        bitc = 0; tg_sda_low <= 1'b0;
        if (first) begin
          first = 0;
          if (!matched) active = 0;
          else if (rdir) begin
            txm = 1; txsh = 8'h11 * (tx_n + 1); tx_n++; tg_sda_low <= !txsh[7];
          end
        end else if (txm) begin
          if (mlast) begin txsh = 8'h11 * (tx_n + 1); tx_n++; tg_sda_low <= !txsh[7]; end
          else txm = 0;
        end else if (nflag) active = 0;
      end
    end
    ps = s; pd = d;
  end

  task automatic tg_clear(input int nk);
    start_n = 0; stop_n = 0; rx_n = 0; tx_n = 0; mack_n = 0; hw_n = 0;
    nack_at = nk; active = 0; txm = 0; addr_log = 8'h00;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] w, input logic [31:0] v);
    @(negedge clk); reg_we = 1'b1; reg_word = w; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] w, output logic [31:0] v);
    @(negedge clk); reg_word = w;
    @(posedge clk); @(negedge clk); v = reg_rdata;
  endtask

  logic busy_seen;
  logic [31:0] last_ctrl;

  task automatic run_list(input logic [31:0] tlo, thi, wlo, whi, input logic [7:0] ad,
                          input logic [13:0] q);
    logic [31:0] ctl, v;
    int guard;
    ctl = {q[13:10], 6'd0, q[9:0], 12'd0};
    reg_write(3'd2, tlo); reg_write(3'd3, thi);
    reg_write(3'd4, wlo); reg_write(3'd5, whi);
    reg_write(3'd1, {24'd0, ad});
    reg_write(3'd0, ctl | 32'd1);
    @(negedge clk);
    reg_read(3'd0, v); busy_seen = v[2];
    guard = 0;
    while (v[2] && guard < 120000) begin reg_read(3'd0, v); guard++; end
    reg_write(3'd0, ctl);
    reg_read(3'd0, last_ctrl);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    reg_read(3'd0, v); chk("R1 ctrl", v, 0);
    reg_read(3'd6, v); chk("R1 rdata", v, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_write;
    logic [31:0] v;
    tg_clear(-1);
    run_list(32'h0006_4421, 0, 32'h0000_A53C, 0, 8'hA0, 14'd4);
    chk("R3 busy seen", busy_seen, 1);
    chk("R3 busy cleared", last_ctrl[3:2], 0);
    chk("R4 addr write", addr_log, 8'hA0);
    chk("R5 byte count", rx_n, 2);
    chk("R5 bytes", {rx_log[1], rx_log[0]}, 16'hA53C);
    chk("R8 start/stop", {start_n[7:0], stop_n[7:0]}, 16'h0101);
    chk("R9 high width q=4", hw_log[1], 8);
    chk("R1 released", {scl_oe, sda_oe}, 0);
    reg_read(3'd2, v); chk("R2 token lo readback", v, 32'h0006_4421);
    reg_read(3'd1, v); chk("R2 addr readback", v, 32'hA0);
  endtask

  task automatic t_wr_rd;
    logic [31:0] v;
    tg_clear(-1);
    run_list(32'h5443_1421, 32'h6, 32'h07, 0, 8'hA0, 14'd4);
    chk("R5 reg byte", {rx_n[7:0], rx_log[0]}, 16'h0107);
    chk("R8 repeated start", start_n, 2);
    chk("R4 addr read", addr_log, 8'hA1);
    reg_read(3'd6, v); chk("R6 rdata lo", v, 32'h0033_2211);
    reg_read(3'd7, v); chk("R6 rdata hi", v, 0);
    chk("R6 ack pattern", {mack_n[3:0], mack_log[0], mack_log[1], mack_log[2]}, 7'b0011_110);
    chk("R8 stop", stop_n, 1);
  endtask

  task automatic t_read6;
    logic [31:0] v;
    tg_clear(-1);
    run_list(32'h5444_4431, 32'h6, 0, 0, 8'hA0, 14'd3);
    reg_read(3'd6, v); chk("R6 six lo", v, 32'h4433_2211);
    reg_read(3'd7, v); chk("R6 six hi", v, 32'h0000_6655);
    chk("R6 last nack", mack_log[5], 0);
  endtask

  task automatic t_addr_nack;
    tg_clear(-1);
    run_list(32'h0006_4421, 0, 32'h0000_A53C, 0, 8'h66, 14'd4);
    chk("R7 err", last_ctrl[3], 1);
    chk("R7 stop", stop_n, 1);
    chk("R7 no data", rx_n, 0);
    chk("R7 released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_data_nack;
    tg_clear(1);
    run_list(32'h0064_4421, 0, 32'h0033_2211, 0, 8'hA0, 14'd4);
    chk("R7 data err", last_ctrl[3], 1);
    chk("R7 abort count", rx_n, 2);
    chk("R7 abort stop", stop_n, 1);
    tg_clear(-1);
    run_list(32'h0006_4421, 0, 32'h0000_A53C, 0, 8'hA0, 14'd4);
    chk("R7 err cleared", last_ctrl[3], 0);
  endtask

  task automatic t_end_early;
    tg_clear(-1);
    run_list(32'h0064_4021, 0, 32'h0000_A53C, 0, 8'hA0, 14'd4);
    chk("R3 end token", {start_n[3:0], stop_n[3:0], rx_n[3:0]}, 12'h100);
    chk("R11 bus held", scl_oe, 1);
    tg_clear(-1);
    run_list(32'h6, 0, 0, 0, 8'hA0, 14'd4);
    chk("R8 stop token", stop_n, 1);
    chk("R11 released after stop", scl_oe, 0);
  endtask

  task automatic t_full16;
    tg_clear(-1);
    run_list(32'h2142_1421, 32'h6421_4214, 32'h0403_0201, 32'h5, 8'hA0, 14'd2);
    chk("R3 sixteen tokens", {start_n[3:0], stop_n[3:0], rx_n[3:0]}, 12'h515);
    chk("R5 bytes 0-4", {rx_log[4], rx_log[3], rx_log[2], rx_log[1], rx_log[0]},
        40'h05_0403_0201);
  endtask

  task automatic t_div;
    tg_clear(-1);
    run_list(32'h0000_0621, 0, 0, 0, 8'hA0, 14'h0400);
    chk("R9 high width q=1024", hw_log[1], 2048);
    chk("R9 run done", last_ctrl[2], 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_write;
    t_wr_rd;
    t_read6;
    t_addr_nack;
    t_data_nack;
    t_end_early;
    t_full16;
    t_div;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule